// File: doc/BRIEF.md
# Serial Two's-Complement Negator

This block negates a binary word that arrives one bit per cycle, least significant bit first, and sends the result out at the same rate. Negation works without an adder. Each bit is passed through unchanged until the first set bit of the word has gone by, and that set bit is passed through as well. Every bit after it is complemented. One flip-flop records whether the first set bit has been seen yet.

The output is a Mealy function of the stored mode and the present input bit. It appears combinationally in the same cycle as the input bit. Each word begins with a start strobe on its least significant bit. That strobe puts the bit through copy mode whatever earlier words left behind, so word lengths may vary and an unfinished word can be dropped at any time. Idle cycles inside a word are allowed and leave the stored mode unchanged. Negating the most negative value of a word gives back the same bit pattern, and no flag is raised.

Top module: `serialNegator`

## Requirements
- R1: After a synchronous reset the block is in copy mode, so the first valid bit after reset is output unchanged even without a start strobe.
- R2: In copy mode a valid 0 gives an output of 0 and the block stays in copy mode.
- R3: In copy mode a valid 1 gives an output of 1, and the block changes to invert mode for the following bits.
- R4: In invert mode every valid bit is output complemented, and the block stays in invert mode until the next start strobe or reset.
- R5: negValid equals bitValid in the same cycle, and negBit is 0 whenever bitValid is low.
- R6: A cycle with bitValid low leaves the mode unchanged, so idle gaps inside a word do not change the result.
- R7: When wordStart and bitValid are high together, that bit is handled in copy mode whatever the previous mode was. wordStart has no effect when bitValid is low.
- R8: Over a complete word of N bits the output word equals (2^N - value) mod 2^N. An all-zero word gives all zeros. The most negative N-bit value gives back the same pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wordStart | input | 1 | Marks the current valid bit as the least significant bit of a new word |
| bitValid | input | 1 | The current cycle carries an input bit |
| bitIn | input | 1 | Serial input bit, least significant bit first |
| negBit | output | 1 | Serial negated bit, combinational in the same cycle |
| negValid | output | 1 | negBit carries a result bit |

## Verification
The assertions assume that bitIn and wordStart are stable and known whenever bitValid is sampled high. They also assume that every word opens with wordStart on its first valid bit, except for the first word after reset. The checker tracks, from the ports only, whether a set bit has gone by since the last start, and it compares each valid output against that. The bench drives all inputs at the falling edge, so they are settled well before each sampling edge. Its random words always begin with a start strobe. Its random idle gaps and restarts in the middle of a word stay within those rules.

// File: rtl/serialNegatorPkg.sv
package serialNegatorPkg;

  // Stored mode: copy until the first set bit has passed, then invert.
  typedef enum logic {
    MODE_COPY   = 1'b0,
    MODE_INVERT = 1'b1
  } negMode_e;

  // Strobes from control to datapath for the current cycle.
  typedef struct packed {
    logic passBit;    // current cycle carries a bit
    logic invertBit;  // complement the current bit
  } negStrobes_t;

endpackage

// File: rtl/serialNegatorCtrl.sv
module serialNegatorCtrl
  import serialNegatorPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wordStart,
  input  logic        bitValid,
  input  logic        bitIn,
  output negStrobes_t strobes
);

  negMode_e modeQ;
  negMode_e modeEff;
  negMode_e modeNext;

  // A start strobe puts the current bit in copy mode (R7).
  always_comb begin
    modeEff = (bitValid && wordStart) ? MODE_COPY : modeQ;
    if (!bitValid) begin
      modeNext = modeQ;                 // idle cycles hold the mode (R6)
    end else if (modeEff == MODE_INVERT) begin
      modeNext = MODE_INVERT;           // stays in invert mode for the word (R4)
    end else begin
      modeNext = bitIn ? MODE_INVERT : MODE_COPY; // first set bit switches (R2, R3)
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ <= MODE_COPY;               // R1
    end else begin
      modeQ <= modeNext;
    end
  end

  always_comb begin
    strobes.passBit   = bitValid;
    strobes.invertBit = (modeEff == MODE_INVERT);
  end

endmodule

// File: rtl/serialNegatorDatapath.sv
module serialNegatorDatapath
  import serialNegatorPkg::*;
(
  input  negStrobes_t strobes,
  input  logic        bitIn,
  output logic        negBit,
  output logic        negValid
);

  always_comb begin
    negValid = strobes.passBit;
    negBit   = strobes.passBit & (bitIn ^ strobes.invertBit);
  end

endmodule

// File: rtl/serialNegator.sv
module serialNegator
  import serialNegatorPkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wordStart,
  input  logic bitValid,
  input  logic bitIn,
  output logic negBit,
  output logic negValid
);

  negStrobes_t strobes;

  serialNegatorCtrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .wordStart(wordStart),
    .bitValid (bitValid),
    .bitIn    (bitIn),
    .strobes  (strobes)
  );

  serialNegatorDatapath uPath (
    .strobes (strobes),
    .bitIn   (bitIn),
    .negBit  (negBit),
    .negValid(negValid)
  );

endmodule

// File: rtl/serialNegatorChecker.sv
module serialNegatorChecker (
  input logic clk,
  input logic rst,
  input logic wordStart,
  input logic bitValid,
  input logic bitIn,
  input logic negBit,
  input logic negValid
);

  // Port-level tracker: has a set input bit passed since reset or the last start.
  logic oneSeen;
  logic oneSeenEff;
  assign oneSeenEff = oneSeen & ~wordStart;

  always_ff @(posedge clk) begin
    if (rst) begin
      oneSeen <= 1'b0;
    end else if (bitValid) begin
      oneSeen <= oneSeenEff | bitIn;
    end
  end

  assert_valid_follow_R5: assert property (@(posedge clk) disable iff (rst)
    negValid == bitValid);

  assert_idle_low_R5: assert property (@(posedge clk) disable iff (rst)
    !bitValid |-> !negBit);

  assert_start_copies_R7: assert property (@(posedge clk) disable iff (rst)
    (bitValid && wordStart) |-> (negBit == bitIn));

  assert_copy_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (bitValid && !oneSeenEff && !bitIn) |-> !negBit);

  assert_copy_first_one_R3: assert property (@(posedge clk) disable iff (rst)
    (bitValid && !oneSeenEff && bitIn) |-> negBit);

  assert_invert_R4: assert property (@(posedge clk) disable iff (rst)
    (bitValid && oneSeenEff) |-> (negBit == !bitIn));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!bitValid && !$past(rst)) |=> (bitValid && !wordStart) |-> (negBit == (bitIn ^ oneSeen)));

endmodule

bind serialNegator serialNegatorChecker uChecker (
  .clk      (clk),
  .rst      (rst),
  .wordStart(wordStart),
  .bitValid (bitValid),
  .bitIn    (bitIn),
  .negBit   (negBit),
  .negValid (negValid)
);

// File: tb/tb_serialNegator.sv
`timescale 1ns/1ps
module tb_serialNegator;

  logic clk = 1'b0;
  logic rst;
  logic wordStart, bitValid, bitIn;
  logic negBit, negValid;

  int checks = 0;
  int fails  = 0;
  bit doneFlag = 0;
  bit modelSeen = 0;   // bench view: a set bit has passed in this word
  int unsigned seed = 32'd20240611;

  always #2.5 clk = ~clk;   // 200 MHz

  serialNegator dut (
    .clk(clk), .rst(rst), .wordStart(wordStart), .bitValid(bitValid),
    .bitIn(bitIn), .negBit(negBit), .negValid(negValid)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic longint unsigned negWord(input longint unsigned v, input int n);
    longint unsigned mask = (n == 64) ? '1 : ((64'd1 << n) - 1);
    return ((~v) + 64'd1) & mask;
  endfunction

  // Drive one cycle, check outputs against the bench model, return the output bit.
  task automatic driveCycle(input bit s, input bit v, input bit b, input string req, output bit o);
    bit expBit;
    @(negedge clk);
    wordStart = s; bitValid = v; bitIn = b;
    #1;
    expBit = v ? (b ^ (modelSeen & ~s)) : 1'b0;
    check(negBit === expBit, req, negBit, expBit);
    check(negValid === v, "R5", negValid, v);
    if (v) modelSeen = (modelSeen & ~s) | b;
    o = negBit;
  endtask

  task automatic sendWord(input longint unsigned val, input int n, input int gapPct, input string req);
    longint unsigned res = 0;
    bit o;
    for (int i = 0; i < n; i++) begin
      while (($urandom % 100) < gapPct) driveCycle(($urandom % 2) == 1, 1'b0, ($urandom % 2) == 1, "R6", o);
      driveCycle(i == 0, 1'b1, val[i], req, o);
      res[i] = o;
    end
    check(res == negWord(val, n), "R8", res, negWord(val, n));
  endtask

  initial begin
    bit o;
    void'($urandom(seed));
    rst = 1; wordStart = 0; bitValid = 0; bitIn = 0;
    repeat (3) @(posedge clk);
    #1;
    check(negValid === 1'b0 && negBit === 1'b0, "R5", {negValid, negBit}, 0);
    @(negedge clk); rst = 0; modelSeen = 0;

    // R1: first bit after reset, no start strobe, copied
    driveCycle(0, 1, 1, "R1", o);
    check(o == 1'b1, "R1", o, 1);
    // R4: now inverting
    driveCycle(0, 1, 1, "R4", o);
    check(o == 1'b0, "R4", o, 0);
    driveCycle(0, 1, 0, "R4", o);
    check(o == 1'b1, "R4", o, 1);
    // R6: idle with stray start strobe keeps invert mode
    driveCycle(1, 0, 1, "R6", o);
    driveCycle(0, 1, 0, "R6", o);
    check(o == 1'b1, "R6", o, 1);
    // R7: start in invert mode copies the bit
    driveCycle(1, 1, 0, "R7", o);
    check(o == 1'b0, "R7", o, 0);
    // R2: copy mode stays for zeros
    driveCycle(0, 1, 0, "R2", o);
    check(o == 1'b0, "R2", o, 0);
    // R3: first one copied then switches
    driveCycle(0, 1, 1, "R3", o);
    check(o == 1'b1, "R3", o, 1);
    driveCycle(0, 1, 1, "R3", o);
    check(o == 1'b0, "R3", o, 0);

    // R8 directed: -3 in 4 bits, zero, most negative, all ones
    sendWord(64'hD, 4, 0, "R8");
    sendWord(64'h0, 8, 0, "R8");
    sendWord(64'h8, 4, 0, "R8");
    sendWord(64'h80000000, 32, 20, "R8");
    sendWord(64'hFFFF, 16, 0, "R8");
    sendWord(64'h1, 1, 0, "R8");

    // Random words with random idle gaps
    for (int w = 0; w < 300; w++) begin
      int n = 1 + ($urandom % 24);
      longint unsigned v = {$urandom, $urandom};
      v = v & ((64'd1 << n) - 1);
      if (($urandom % 8) == 0) v = 0;
      sendWord(v, n, 15, "R8");
      if (($urandom % 6) == 0) begin   // aborted word, next start must recover
        for (int k = 0; k < 3; k++) driveCycle(k == 0, 1, ($urandom % 2) == 1, "R7", o);
      end
    end

    @(negedge clk); bitValid = 0; wordStart = 0;
    if (!doneFlag) begin
      doneFlag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    end
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!doneFlag) begin
      doneFlag = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    end
    $finish;
  end

endmodule